// File: doc/BRIEF.md
# Time-Slotted Circuit Router

This block forwards words between neighbouring routers of an on-chip network that shares time in fixed slots. Each of its N input links and N output links carries at most one token per slot: a valid flag and a W-bit word. A token that arrives in one slot leaves one slot later, on every output that the schedule connects to its input at that later slot. The schedule is a table with one entry per (slot, output) pair. Each entry names a source input and carries an enable flag. Because the schedule is fixed ahead of time and never lets two inputs compete for one output, the router needs no arbiter, no routing header and no flow control. The data word passes through untouched.

A slot counter runs through the S slots of a round and wraps. Every router in the network stays on the same slot number. A small state machine drives the counter. It is in ST_PRIME during reset and in the first slot after reset, when every output emits an empty token so that neighbours can start their own slot sequence. It is in ST_LAST during slot S-1 and in ST_RUN otherwise. The transitions are ST_PRIME→ST_RUN or ST_LAST, ST_RUN→ST_LAST when the next slot is S-1, and ST_LAST→ST_RUN. The next state is chosen only by the next slot number. A configuration port writes a shadow copy of the table. The shadow copy becomes the live copy on the clock edge that ends slot S-1, so a round already under way is never disturbed.

Top module: `tdm_circuit_router`

## Requirements
- R1: While reset is asserted, and in the first slot after reset is released, `cur_slot` is 0 and every output shows valid=0 and data=0.
- R2: `cur_slot` rises by one on each clock edge outside reset and goes from S-1 back to 0.
- R3: The token (valid bit and all W data bits) captured on input i during slot s appears in slot s+1 on output o whenever the live entry (s+1, o) is enabled and selects i. Empty tokens are forwarded the same way, data included.
- R4: Several outputs may select the same input in the same slot, and each of them carries a copy of that input's token.
- R5: An output whose live entry is disabled, or selects an index of N or more, shows valid=0 and data=0.
- R6: A configuration write stores {`cfg_en`, `cfg_sel`} into shadow entry (`cfg_slot`, `cfg_out`) when `cfg_wr_en` is high at a clock edge. A write with `cfg_out` ≥ N or `cfg_slot` ≥ S changes nothing.
- R7: A shadow entry written at any edge becomes live from the next slot 0. Slots that remain in the current round use the earlier contents. A write made during slot S-1 applies from the slot 0 that immediately follows.
- R8: Reset clears every table entry, so all outputs stay empty until entries are written and a round boundary has passed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Network clock, one slot per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | N | Full flag of the token on each input link |
| in_data | input | N*W | Word on each input link, link i in bits [i*W +: W] |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_slot | input | max(1,clog2(S)) | Slot of the entry being written |
| cfg_out | input | max(1,clog2(N)) | Output of the entry being written |
| cfg_sel | input | max(1,clog2(N)) | Source input stored in the entry |
| cfg_en | input | 1 | Enable stored in the entry |
| out_valid | output | N | Full flag of the token on each output link |
| out_data | output | N*W | Word on each output link, link o in bits [o*W +: W] |
| cur_slot | output | max(1,clog2(S)) | Slot number of the current cycle |

## Verification
The route assertions assume that the inputs are stable at each clock edge and that reset is released between edges, so the sampled value one edge back is the token the input register captured. The stimulus meets this by changing every input, reset included, only on the falling clock edge. The assertions do not depend on the schedule being free of conflicts, since the multicast cases have several outputs reading one input on purpose. The stimulus writes entries in every slot of the round, including entries whose index is out of range and writes that land in slot S-1.

// File: rtl/tdm_rt_pkg.sv
package tdm_rt_pkg;

    typedef enum logic [1:0] {
        ST_PRIME = 2'd0,
        ST_RUN   = 2'd1,
        ST_LAST  = 2'd2
    } rt_state_e;

    function automatic int idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/tdm_rt_slot_fsm.sv
module tdm_rt_slot_fsm
    import tdm_rt_pkg::*;
#(
    parameter int S = 16,
    localparam int SLW = idx_w(S)
) (
    input  logic           clk,
    input  logic           rst_n,
    output logic [SLW-1:0] slot_q,
    output logic           prime,
    output logic           commit
);

    localparam logic [SLW-1:0] LAST_SLOT = SLW'(S - 1);

    rt_state_e      st_q;
    rt_state_e      st_nx;
    logic [SLW-1:0] slot_nx;

    always_comb begin
        if (slot_q == LAST_SLOT) slot_nx = '0;
        else                     slot_nx = slot_q + 1'b1;
    end

    always_comb begin
        st_nx = ST_RUN;
        unique case (st_q)
            ST_PRIME: st_nx = (slot_nx == LAST_SLOT) ? ST_LAST : ST_RUN;
            ST_RUN:   st_nx = (slot_nx == LAST_SLOT) ? ST_LAST : ST_RUN;
            ST_LAST:  st_nx = (slot_nx == LAST_SLOT) ? ST_LAST : ST_RUN;
            default:  st_nx = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_PRIME;
        else        st_q <= st_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) slot_q <= '0;
        else        slot_q <= slot_nx;
    end

    always_comb begin
        prime  = 1'b0;
        commit = 1'b0;
        unique case (st_q)
            ST_PRIME: begin
                prime  = 1'b1;
                commit = (S == 1);
            end
            ST_RUN:   commit = 1'b0;
            ST_LAST:  commit = 1'b1;
            default:  commit = 1'b0;
        endcase
    end

    assert_slot_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> slot_q == (($past(slot_q) == LAST_SLOT) ? '0 : $past(slot_q) + 1'b1));

    assert_commit_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> slot_q == LAST_SLOT);

    assert_prime_slot0_R1: assert property (@(posedge clk) disable iff (!rst_n)
        prime |-> slot_q == '0);

endmodule

// File: rtl/tdm_rt_sched_table.sv
module tdm_rt_sched_table
    import tdm_rt_pkg::*;
#(
    parameter int N = 5,
    parameter int S = 16,
    localparam int SELW = idx_w(N),
    localparam int SLW  = idx_w(S),
    localparam int EW   = SELW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  logic              cfg_wr_en,
    input  logic [SLW-1:0]    cfg_slot,
    input  logic [SELW-1:0]   cfg_out,
    input  logic [SELW-1:0]   cfg_sel,
    input  logic              cfg_en,
    input  logic [SLW-1:0]    rd_slot,
    output logic [N-1:0]      row_en,
    output logic [N*SELW-1:0] row_sel
);

    logic [S-1:0][N-1:0][EW-1:0] shadow_q;
    logic [S-1:0][N-1:0][EW-1:0] shadow_d;
    logic [S-1:0][N-1:0][EW-1:0] live_q;
    logic                        wr_ok;

    assign wr_ok = cfg_wr_en && (int'(cfg_slot) < S) && (int'(cfg_out) < N);

    always_comb begin
        shadow_d = shadow_q;
        if (wr_ok) shadow_d[cfg_slot][cfg_out] = {cfg_en, cfg_sel};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) shadow_q <= '0;
        else        shadow_q <= shadow_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      live_q <= '0;
        else if (commit) live_q <= shadow_d;
    end

    for (genvar o = 0; o < N; o++) begin : g_row
        assign row_en[o]                 = live_q[rd_slot][o][EW-1];
        assign row_sel[o*SELW +: SELW]   = live_q[rd_slot][o][SELW-1:0];
    end

    assert_live_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(live_q));

    assert_bad_write_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_wr_en && int'(cfg_out) < N && int'(cfg_slot) < S) |=> $stable(shadow_q));

endmodule

// File: rtl/tdm_rt_in_stage.sv
module tdm_rt_in_stage #(
    parameter int N = 5,
    parameter int W = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [N-1:0]   in_valid,
    input  logic [N*W-1:0] in_data,
    output logic [N-1:0]   reg_v,
    output logic [N*W-1:0] reg_d
);

    for (genvar i = 0; i < N; i++) begin : g_port
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                reg_v[i]         <= 1'b0;
                reg_d[i*W +: W]  <= '0;
            end else begin
                reg_v[i]         <= in_valid[i];
                reg_d[i*W +: W]  <= in_data[i*W +: W];
            end
        end
    end

endmodule

// File: rtl/tdm_rt_xbar.sv
module tdm_rt_xbar
    import tdm_rt_pkg::*;
#(
    parameter int N = 5,
    parameter int W = 32,
    localparam int SELW = idx_w(N)
) (
    input  logic              prime,
    input  logic [N-1:0]      row_en,
    input  logic [N*SELW-1:0] row_sel,
    input  logic [N-1:0]      reg_v,
    input  logic [N*W-1:0]    reg_d,
    output logic [N-1:0]      out_valid,
    output logic [N*W-1:0]    out_data
);

    for (genvar o = 0; o < N; o++) begin : g_out
        logic [SELW-1:0] sel;
        logic            v;
        logic [W-1:0]    d;

        assign sel = row_sel[o*SELW +: SELW];

        always_comb begin
            v = 1'b0;
            d = '0;
            if (!prime && row_en[o]) begin
                for (int i = 0; i < N; i++) begin
                    if (sel == SELW'(i)) begin
                        v = reg_v[i];
                        d = reg_d[i*W +: W];
                    end
                end
            end
        end

        assign out_valid[o]        = v;
        assign out_data[o*W +: W]  = d;
    end

endmodule

// File: rtl/tdm_circuit_router.sv
module tdm_circuit_router
    import tdm_rt_pkg::*;
#(
    parameter int N = 5,
    parameter int W = 32,
    parameter int S = 16,
    localparam int SELW = idx_w(N),
    localparam int SLW  = idx_w(S)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N-1:0]    in_valid,
    input  logic [N*W-1:0]  in_data,
    input  logic            cfg_wr_en,
    input  logic [SLW-1:0]  cfg_slot,
    input  logic [SELW-1:0] cfg_out,
    input  logic [SELW-1:0] cfg_sel,
    input  logic            cfg_en,
    output logic [N-1:0]    out_valid,
    output logic [N*W-1:0]  out_data,
    output logic [SLW-1:0]  cur_slot
);

    logic              prime;
    logic              commit;
    logic [SLW-1:0]    slot_q;
    logic [N-1:0]      row_en;
    logic [N*SELW-1:0] row_sel;
    logic [N-1:0]      reg_v;
    logic [N*W-1:0]    reg_d;

    tdm_rt_slot_fsm #(.S(S)) u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .slot_q (slot_q),
        .prime  (prime),
        .commit (commit)
    );

    tdm_rt_sched_table #(.N(N), .S(S)) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .commit    (commit),
        .cfg_wr_en (cfg_wr_en),
        .cfg_slot  (cfg_slot),
        .cfg_out   (cfg_out),
        .cfg_sel   (cfg_sel),
        .cfg_en    (cfg_en),
        .rd_slot   (slot_q),
        .row_en    (row_en),
        .row_sel   (row_sel)
    );

    tdm_rt_in_stage #(.N(N), .W(W)) u_in (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_data  (in_data),
        .reg_v    (reg_v),
        .reg_d    (reg_d)
    );

    tdm_rt_xbar #(.N(N), .W(W)) u_xbar (
        .prime     (prime),
        .row_en    (row_en),
        .row_sel   (row_sel),
        .reg_v     (reg_v),
        .reg_d     (reg_d),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    assign cur_slot = slot_q;

    assert_prime_empty_R1: assert property (@(posedge clk) disable iff (!rst_n)
        prime |-> (out_valid == '0 && out_data == '0));

    for (genvar o = 0; o < N; o++) begin : g_chk
        logic [SELW-1:0] sel_o;
        assign sel_o = row_sel[o*SELW +: SELW];

        assert_route_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (!prime && row_en[o] && int'(sel_o) < N)
            |-> out_valid[o] == |($past(in_valid) & (N'(1) << sel_o)));

        assert_route_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (!prime && row_en[o] && int'(sel_o) < N)
            |-> out_data[o*W +: W] == W'($past(in_data) >> (int'(sel_o) * W)));

        assert_unused_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (!prime && (!row_en[o] || int'(sel_o) >= N))
            |-> (!out_valid[o] && out_data[o*W +: W] == '0));
    end

endmodule

// File: tb/tdm_circuit_router_bench.sv
`timescale 1ns/1ps
module tdm_circuit_router_bench;

    localparam int N    = 5;
    localparam int W    = 32;
    localparam int S    = 16;
    localparam int SLW  = 4;
    localparam int SELW = 3;
    localparam real HALF = 4.0;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N-1:0]    in_valid = '0;
    logic [N*W-1:0]  in_data = '0;
    logic            cfg_wr_en = 1'b0;
    logic [SLW-1:0]  cfg_slot = '0;
    logic [SELW-1:0] cfg_out = '0;
    logic [SELW-1:0] cfg_sel = '0;
    logic            cfg_en = 1'b0;
    logic [N-1:0]    out_valid;
    logic [N*W-1:0]  out_data;
    logic [SLW-1:0]  cur_slot;

    int   nvec = 0;
    int   nbad = 0;
    bit   done = 0;
    logic [31:0] seed = 32'h1234_5678;

    bit          m_sh_en [S][N];
    int          m_sh_sel[S][N];
    bit          m_lv_en [S][N];
    int          m_lv_sel[S][N];
    bit          m_rv[N];
    logic [W-1:0] m_rd[N];
    int          m_slot;
    bit          m_prime;

    tdm_circuit_router #(.N(N), .W(W), .S(S)) u_tdm_circuit_router (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .cfg_wr_en(cfg_wr_en), .cfg_slot(cfg_slot), .cfg_out(cfg_out),
        .cfg_sel(cfg_sel), .cfg_en(cfg_en), .out_valid(out_valid),
        .out_data(out_data), .cur_slot(cur_slot)
    );

    always #(HALF) clk = ~clk;

    function automatic logic [31:0] rnd();
        seed = seed * 32'd1103515245 + 32'd12345;
        return {seed[15:0], seed[31:16]};
    endfunction

    task automatic model_reset();
        for (int s = 0; s < S; s++)
            for (int o = 0; o < N; o++) begin
                m_sh_en[s][o] = 0; m_sh_sel[s][o] = 0;
                m_lv_en[s][o] = 0; m_lv_sel[s][o] = 0;
            end
        for (int i = 0; i < N; i++) begin m_rv[i] = 0; m_rd[i] = '0; end
        m_slot = 0;
        m_prime = 1;
    endtask

    task automatic model_step();
        if (!rst_n) begin
            model_reset();
        end else begin
            for (int i = 0; i < N; i++) begin
                m_rv[i] = in_valid[i];
                m_rd[i] = in_data[i*W +: W];
            end
            if (cfg_wr_en && int'(cfg_out) < N && int'(cfg_slot) < S) begin
                m_sh_en[cfg_slot][cfg_out]  = cfg_en;
                m_sh_sel[cfg_slot][cfg_out] = int'(cfg_sel);
            end
            if (m_slot == S - 1) begin
                m_lv_en  = m_sh_en;
                m_lv_sel = m_sh_sel;
            end
            m_slot  = (m_slot + 1) % S;
            m_prime = 0;
        end
    endtask

    task automatic check_now(input string note);
        string req;
        bit ev;
        logic [W-1:0] ed;
        int shares;
        nvec++;
        if (int'(cur_slot) != m_slot) begin
            nbad++;
            $display("FAIL R2 %s cur_slot actual=%0d expected=%0d", note, cur_slot, m_slot);
        end
        for (int o = 0; o < N; o++) begin
            nvec++;
            ev = 0; ed = '0;
            if (m_prime) begin
                req = "R1";
            end else if (!m_lv_en[m_slot][o] || m_lv_sel[m_slot][o] >= N) begin
                req = "R5";
            end else begin
                ev = m_rv[m_lv_sel[m_slot][o]];
                ed = m_rd[m_lv_sel[m_slot][o]];
                shares = 0;
                for (int p = 0; p < N; p++)
                    if (m_lv_en[m_slot][p] && m_lv_sel[m_slot][p] == m_lv_sel[m_slot][o]) shares++;
                req = (shares > 1) ? "R4" : "R3";
            end
            if (out_valid[o] !== ev || out_data[o*W +: W] !== ed) begin
                nbad++;
                $display("FAIL %s %s slot=%0d out=%0d actual=%0b/%h expected=%0b/%h",
                         req, note, m_slot, o, out_valid[o], out_data[o*W +: W], ev, ed);
            end
        end
    endtask

    task automatic drive_random();
        in_valid = N'(rnd());
        for (int i = 0; i < N; i++) in_data[i*W +: W] = rnd();
    endtask

    task automatic step(input string note);
        @(posedge clk);
        model_step();
        @(negedge clk);
        check_now(note);
    endtask

    task automatic run(input int n, input string note);
        for (int k = 0; k < n; k++) begin
            drive_random();
            step(note);
        end
    endtask

    task automatic write_one(input int s, input int o, input int sel, input bit en, input string note);
        cfg_wr_en = 1'b1;
        cfg_slot  = SLW'(s);
        cfg_out   = SELW'(o);
        cfg_sel   = SELW'(sel);
        cfg_en    = en;
        drive_random();
        step(note);
        cfg_wr_en = 1'b0;
    endtask

    initial begin
        #(HALF * 2.0 * 150000.0);
        if (!done) begin
            nbad++;
            $display("FAIL R2 watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: first slot after release is empty, slot 0
        check_now("R1 reset release");

        // R8: cleared table keeps every output empty
        run(2 * S, "R8 empty table");

        // R6: program every entry; some selects are out of range (R5)
        for (int s = 0; s < S; s++) begin
            for (int o = 0; o < N; o++) begin
                int sel;
                bit en;
                sel = (s + 2 * o) % 8;
                en  = ((s + o) % 5) != 4;
                if (s == 3) begin sel = 2; en = 1; end          // R4 multicast
                if (s == 7 && o < 2) begin sel = 4; en = 1; end // R4 pair
                write_one(s, o, sel, en, "R6 program");
            end
            // R6: out-of-range output index must change nothing
            write_one(s, 5 + (s % 3), 0, 1, "R6 bad output index");
        end

        // R3/R4/R5: several full rounds with varied traffic
        run(3 * S, "R3 random traffic");
        for (int k = 0; k < S; k++) begin
            in_valid = '0;
            for (int i = 0; i < N; i++) in_data[i*W +: W] = rnd();
            step("R3 empty tokens forwarded");
        end
        for (int k = 0; k < S; k++) begin
            in_valid = '1;
            for (int i = 0; i < N; i++) in_data[i*W +: W] = {8'(i), 8'(k), 16'hA5C3};
            step("R3 all full");
        end

        // R7: rewrite slot 9 while round is in progress
        while (m_slot != 2) run(1, "R7 align");
        for (int o = 0; o < N; o++) write_one(9, o, 1, 1, "R7 mid-round write");
        run(S, "R7 effect after boundary");

        // R7: write during last slot applies from the very next slot 0
        while (m_slot != S - 1) run(1, "R7 align last");
        write_one(0, 0, 0, 1, "R7 last-slot write");
        run(2 * S, "R7 after last-slot write");

        // R1/R8: reset mid-run clears everything
        @(negedge clk);
        rst_n = 1'b0;
        step("R1 in reset");
        step("R1 in reset");
        @(negedge clk);
        rst_n = 1'b1;
        check_now("R1 second release");
        run(2 * S, "R8 table cleared by reset");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

endmodule